// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is an SMBus target that owns a small bank of byte-wide control registers. The rest of the chip sees every register at once on a flat parallel bus. The host on the two-wire bus reaches the bank through indexed block transfers. Every transfer begins with a register index. A write then carries a byte count and a burst of data. A read is made of the index phase, then a repeated start with the read address. The target answers with a count byte, taken from a dedicated count register, and then streams register contents starting at the index.

SCL and SDA arrive as raw samples in the system clock domain. Each line passes through a two-flop synchronizer and a glitch filter before start and stop conditions and clock edges are decoded. The target drives the bus only through an open-drain pull-down enable. Acknowledges, address matching, index stepping, count limits and aborts are all handled inside the block. No clock stretching is used.

Top module: `smb_regbank`

## Requirements
- R1: After reset, every register reads 0x00 except index 8 (the count register), which reads 0x04, and index 15 (read-only), which reads 0xA5. The SDA pull-down is released.
- R2: The target acknowledges address byte 0xDC (write) and 0xDD (read), that is 7-bit address 0x6E, by holding SDA low for the ninth clock. It gives no acknowledge to any other address and does not drive SDA again until the next start.
- R3: In a write, the first byte after the address is the start index N and the second is the byte count X. The next X data bytes are acknowledged and stored in registers N, N+1, and so on.
- R4: Data bytes beyond the byte count are acknowledged and discarded.
- R5: After an index-only write phase and a repeated start with 0xDD, the target sends the count register value first and then the registers from index N upward, each byte MSB first.
- R6: When the host leaves a transmitted byte unacknowledged (SDA high on the ninth clock), the target releases SDA and drives nothing more until the next start.
- R7: After every data byte the index steps by one, and it wraps from 15 to 0.
- R8: Writes to the read-only index 15 or to any index of 16 or more are acknowledged and change no register. Reads of indices of 16 or more return 0x00.
- R9: A stop or start that arrives in the middle of a byte aborts the transfer and commits no partial byte. A start also begins a new transfer.
- R10: The target changes its SDA drive only while the filtered SCL is low.
- R11: Pulses on either line shorter than the filter length (3 system clocks) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Raw sample of the SMBus clock line |
| sda_i | input | 1 | Raw sample of the SMBus data line |
| sda_pull_o | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | 128 | Register bank, register k at bits [8k+7:8k] |

## Verification
A register is committed on the SCL fall that ends its acknowledge clock, plus two sync flops and three filter cycles. The target's drive on SDA follows each SCL fall after the same six-cycle path. The bench runs the bus with 10-cycle quarter periods. It samples SDA in the middle of SCL high, long after any drive change has settled. It reads the register view only after the stop, once every commit has landed. The bus driver pushes each expected acknowledge, returned byte and register value into a queue. A monitor pairs these with the observed values in the order they occur.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK
  } smb_state_e;

  // Index step: wraps inside the bank, plain increment outside it.
  function automatic logic [7:0] idx_next(input logic [7:0] idx, input int unsigned nreg);
    if ({1'b0, idx} == 9'(nreg - 1)) return 8'h00;
    return idx + 8'h01;
  endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned FILT    = 3,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = (FILT > 1) ? $clog2(FILT) : 1;

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (s2_q == out_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(FILT - 1)) begin
      out_d = s2_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= RST_VAL;
      s2_q  <= RST_VAL;
      cnt_q <= '0;
      out_q <= RST_VAL;
    end else begin
      s1_q  <= raw_i;
      s2_q  <= s1_q;
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign filt_o = out_q;

  // R11: the output only ever moves to a level the synchronized input held.
  p_filter_follows_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(out_q) |-> ($past(s2_q) == out_q));

endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
  input  logic clk,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_f_i;
      sda_p_q <= sda_f_i;
    end
  end

  assign start_o = scl_f_i & scl_p_q & sda_p_q & ~sda_f_i;
  assign stop_o  = scl_f_i & scl_p_q & ~sda_p_q & sda_f_i;
  assign rise_o  = scl_f_i & ~scl_p_q;
  assign fall_o  = ~scl_f_i & scl_p_q;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int unsigned         NREG    = 16,
  parameter int unsigned         CNT_IDX = 8,
  parameter logic [7:0]          CNT_RST = 8'h04,
  parameter logic [NREG-1:0]     RO_MASK = 16'h8000,
  parameter logic [7:0]          RO_VAL  = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_idx_i,
  input  logic [7:0]        wr_data_i,
  input  logic [7:0]        rd_idx_i,
  output logic [7:0]        rd_data_o,
  output logic [7:0]        cnt_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IW = $clog2(NREG);

  logic [7:0] regs [NREG];
  logic       wr_in_rng;

  assign wr_in_rng = ({1'b0, wr_idx_i} < 9'(NREG));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RV = (g == CNT_IDX) ? CNT_RST : (RO_MASK[g] ? RO_VAL : 8'h00);
    if (RO_MASK[g]) begin : g_ro
      assign regs[g] = RV;
    end else begin : g_rw
      logic hit;
      assign hit = wr_en_i && wr_in_rng && (wr_idx_i[IW-1:0] == IW'(g));
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)  regs[g] <= RV;
        else if (hit) regs[g] <= wr_data_i;
      end
    end
    assign regs_o[g*8 +: 8] = regs[g];
  end

  assign rd_data_o = ({1'b0, rd_idx_i} < 9'(NREG)) ? regs[rd_idx_i[IW-1:0]] : 8'h00;
  assign cnt_o     = regs[CNT_IDX];

  // R3: a write to a writable index lands in that register.
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && wr_in_rng && !RO_MASK[wr_idx_i[IW-1:0]])
      |=> (regs[$past(wr_idx_i[IW-1:0])] == $past(wr_data_i)));

  // R8: a write outside the bank changes nothing.
  p_oob_quiet_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && !wr_in_rng) |=> $stable(regs_o));

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int unsigned     NREG    = 16,
  parameter int unsigned     CNT_IDX = 8,
  parameter logic [7:0]      CNT_RST = 8'h04,
  parameter logic [NREG-1:0] RO_MASK = 16'h8000,
  parameter logic [7:0]      RO_VAL  = 8'hA5,
  parameter logic [6:0]      ADDR7   = 7'h6E,
  parameter int unsigned     FILT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [NREG*8-1:0] regs_o
);
  import smb_pkg::*;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic scl_f, sda_f, ev_start, ev_stop, ev_rise, ev_fall;

  smb_line_filter #(.FILT(FILT), .RST_VAL(1'b1)) u_scl_filt (
    .clk(clk), .rst_ni(rst_ni), .raw_i(scl_i), .filt_o(scl_f));
  smb_line_filter #(.FILT(FILT), .RST_VAL(1'b1)) u_sda_filt (
    .clk(clk), .rst_ni(rst_ni), .raw_i(sda_i), .filt_o(sda_f));

  smb_cond_detect u_cond (
    .clk(clk), .rst_ni(rst_ni), .scl_f_i(scl_f), .sda_f_i(sda_f),
    .start_o(ev_start), .stop_o(ev_stop), .rise_o(ev_rise), .fall_o(ev_fall));

  smb_state_e state_q, state_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] idx_q, idx_d;
  logic [7:0] rem_q, rem_d;
  logic [1:0] ph_q, ph_d;
  logic       pull_q, pull_d;
  logic       nack_q, nack_d;
  logic       wr_en;
  logic [7:0] rd_data, cnt_val;

  smb_regfile #(
    .NREG(NREG), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST),
    .RO_MASK(RO_MASK), .RO_VAL(RO_VAL)
  ) u_rf (
    .clk(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(idx_q),
    .wr_data_i(sh_q), .rd_idx_i(idx_q), .rd_data_o(rd_data),
    .cnt_o(cnt_val), .regs_o(regs_o));

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    rem_d   = rem_q;
    ph_d    = ph_q;
    pull_d  = pull_q;
    nack_d  = nack_q;
    wr_en   = 1'b0;
    if (ev_stop) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else if (ev_start) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      ph_d    = '0;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (ev_rise && bit_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_f};
            bit_d = bit_q + 4'd1;
          end else if (ev_fall && bit_q == 4'd8) begin
            bit_d = '0;
            if (state_q == ST_RX) begin
              state_d = ST_RACK;
              pull_d  = 1'b1;
            end else if (sh_q[7:1] == ADDR7) begin
              state_d = ST_AACK;
              pull_d  = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_AACK: if (ev_fall) begin
          if (sh_q[0]) begin
            state_d = ST_TX;
            sh_d    = cnt_val;
            pull_d  = ~cnt_val[7];
          end else begin
            state_d = ST_RX;
            pull_d  = 1'b0;
          end
        end
        ST_RACK: if (ev_fall) begin
          state_d = ST_RX;
          pull_d  = 1'b0;
          unique case (ph_q)
            2'd0: begin idx_d = sh_q; ph_d = 2'd1; end
            2'd1: begin rem_d = sh_q; ph_d = 2'd2; end
            default: if (rem_q != 8'h00) begin
              wr_en = 1'b1;
              rem_d = rem_q - 8'h01;
              idx_d = idx_next(idx_q, NREG);
            end
          endcase
        end
        ST_TX: if (ev_fall) begin
          if (bit_q == 4'd7) begin
            state_d = ST_TACK;
            pull_d  = 1'b0;
            bit_d   = '0;
          end else begin
            sh_d   = {sh_q[6:0], 1'b0};
            pull_d = ~sh_q[6];
            bit_d  = bit_q + 4'd1;
          end
        end
        ST_TACK: begin
          if (ev_rise) begin
            nack_d = sda_f;
          end else if (ev_fall) begin
            if (nack_q) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_TX;
              sh_d    = rd_data;
              pull_d  = ~rd_data[7];
              idx_d   = idx_next(idx_q, NREG);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
      ph_q    <= '0;
      pull_q  <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
      ph_q    <= ph_d;
      pull_q  <= pull_d;
      nack_q  <= nack_d;
    end
  end

  assign sda_pull_o = pull_q;

  // R10: SDA drive moves only in the SCL low phase.
  p_sda_low_phase_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(pull_q) |-> !scl_f);

  // R6: once off the bus the target drives nothing.
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !pull_q);

  // R2: the address acknowledge holds SDA low throughout.
  p_addr_ack_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_AACK) |-> pull_q);

  // R9: the bit counter never runs past a full byte.
  p_bit_range_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    bit_q <= 4'd8);

endmodule

// File: tb/smb_regbank_bench.sv
module smb_regbank_bench;
  localparam int Q    = 10;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_pull;
  logic [NREG*8-1:0] regs;
  logic sda_line;

  always #10 clk = ~clk;

  assign sda_line = sda_h & ~sda_pull;

  smb_regbank u_smb_regbank (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .regs_o(regs));

  typedef struct { logic [7:0] val; string tag; } item_t;
  item_t      exp_q[$];
  logic [7:0] act_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Monitor: pairs observed results with expected ones in order.
  initial begin
    forever begin
      @(posedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        item_t      e;
        logic [7:0] a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        checks++;
        if (a !== e.val) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", e.tag, a, e.val);
        end
      end
    end
  end

  task automatic expect_val(input logic [7:0] e, input logic [7:0] a, input string tag);
    item_t it;
    it.val = e;
    it.tag = tag;
    exp_q.push_back(it);
    act_q.push_back(a);
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wq(Q);
    scl_h = 1'b1; wq(Q);
    sda_h = 1'b0; wq(Q);
    scl_h = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(Q);
    scl_h = 1'b1; wq(Q);
    sda_h = 1'b1; wq(3 * Q);
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    sda_h = b; wq(Q);
    if (glitch) begin
      scl_h = 1'b1; wq(1);
      scl_h = 1'b0; wq(2);
    end
    scl_h = 1'b1; wq(2 * Q);
    scl_h = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_h = 1'b1; wq(Q);
    scl_h = 1'b1; wq(Q);
    b = sda_line; wq(Q);
    scl_h = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string tag,
                           input bit glitch = 1'b0);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
    get_bit(a);
    expect_val({7'd0, exp_ack}, {7'd0, a}, tag);
  endtask

  task automatic recv_byte(input logic [7:0] e, input bit host_ack, input string tag);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    expect_val(e, v, tag);
    put_bit(host_ack ? 1'b0 : 1'b1, 1'b0);
  endtask

  task automatic chk_reg(input int k, input logic [7:0] e, input string tag);
    expect_val(e, regs[k*8 +: 8], tag);
  endtask

  initial begin
    logic b;
    wq(5);
    rst_n = 1'b1;
    wq(10);
    // R1 reset state
    for (int k = 0; k < NREG; k++)
      chk_reg(k, (k == 8) ? 8'h04 : ((k == 15) ? 8'hA5 : 8'h00), "R1 reset value");
    expect_val(8'h01, {7'd0, sda_line}, "R1 sda released");

    // R3 block write of 3 bytes at index 2, address ack R2
    bus_start();
    send_byte(8'hDC, 1'b0, "R2 write address ack");
    send_byte(8'h02, 1'b0, "R3 index ack");
    send_byte(8'h03, 1'b0, "R3 count ack");
    send_byte(8'h11, 1'b0, "R3 data ack");
    send_byte(8'h22, 1'b0, "R3 data ack");
    send_byte(8'h33, 1'b0, "R3 data ack");
    bus_stop();
    chk_reg(2, 8'h11, "R3 reg2");
    chk_reg(3, 8'h22, "R3 reg3");
    chk_reg(4, 8'h33, "R3 reg4");
    chk_reg(5, 8'h00, "R3 reg5 untouched");

    // R4 bytes beyond count
    bus_start();
    send_byte(8'hDC, 1'b0, "R2 write address ack");
    send_byte(8'h06, 1'b0, "R4 index ack");
    send_byte(8'h01, 1'b0, "R4 count ack");
    send_byte(8'h5A, 1'b0, "R4 data ack");
    send_byte(8'h77, 1'b0, "R4 extra byte ack");
    bus_stop();
    chk_reg(6, 8'h5A, "R4 reg6");
    chk_reg(7, 8'h00, "R4 extra byte discarded");

    // R2 foreign address ignored
    bus_start();
    send_byte(8'hB0, 1'b1, "R2 foreign address nack");
    send_byte(8'h55, 1'b1, "R2 stays off bus");
    bus_stop();
    chk_reg(5, 8'h00, "R2 no write");

    // R7 wrap and R8 read-only
    bus_start();
    send_byte(8'hDC, 1'b0, "R2 write address ack");
    send_byte(8'h0E, 1'b0, "R7 index ack");
    send_byte(8'h03, 1'b0, "R7 count ack");
    send_byte(8'hC1, 1'b0, "R7 data ack");
    send_byte(8'hC2, 1'b0, "R8 read-only byte ack");
    send_byte(8'hC3, 1'b0, "R7 data ack");
    bus_stop();
    chk_reg(14, 8'hC1, "R7 reg14");
    chk_reg(15, 8'hA5, "R8 read-only kept");
    chk_reg(0, 8'hC3, "R7 wrapped to reg0");

    // R8 out-of-range write
    bus_start();
    send_byte(8'hDC, 1'b0, "R2 write address ack");
    send_byte(8'h40, 1'b0, "R8 index ack");
    send_byte(8'h01, 1'b0, "R8 count ack");
    send_byte(8'h99, 1'b0, "R8 out-of-range byte ack");
    bus_stop();
    chk_reg(0, 8'hC3, "R8 reg0 unchanged");
    chk_reg(1, 8'h00, "R8 reg1 unchanged");

    // set count register to 3
    bus_start();
    send_byte(8'hDC, 1'b0, "R2 write address ack");
    send_byte(8'h08, 1'b0, "R3 index ack");
    send_byte(8'h01, 1'b0, "R3 count ack");
    send_byte(8'h03, 1'b0, "R3 data ack");
    bus_stop();
    chk_reg(8, 8'h03, "R3 count register");

    // R5 read from index 2, R6 nack end
    bus_start();
    send_byte(8'hDC, 1'b0, "R2 write address ack");
    send_byte(8'h02, 1'b0, "R5 index ack");
    bus_start();
    send_byte(8'hDD, 1'b0, "R2 read address ack");
    recv_byte(8'h03, 1'b1, "R5 count byte");
    recv_byte(8'h11, 1'b1, "R5 reg2");
    recv_byte(8'h22, 1'b1, "R5 reg3");
    recv_byte(8'h33, 1'b0, "R5 reg4");
    get_bit(b);
    expect_val(8'h01, {7'd0, b}, "R6 released after nack");
    get_bit(b);
    expect_val(8'h01, {7'd0, b}, "R6 still released");
    bus_stop();

    // R7 read wrap, R8 out-of-range read
    bus_start();
    send_byte(8'hDC, 1'b0, "R2 write address ack");
    send_byte(8'h0F, 1'b0, "R7 index ack");
    bus_start();
    send_byte(8'hDD, 1'b0, "R2 read address ack");
    recv_byte(8'h03, 1'b1, "R5 count byte");
    recv_byte(8'hA5, 1'b1, "R7 reg15");
    recv_byte(8'hC3, 1'b0, "R7 wrapped reg0");
    bus_stop();
    bus_start();
    send_byte(8'hDC, 1'b0, "R2 write address ack");
    send_byte(8'h30, 1'b0, "R8 index ack");
    bus_start();
    send_byte(8'hDD, 1'b0, "R2 read address ack");
    recv_byte(8'h03, 1'b1, "R5 count byte");
    recv_byte(8'h00, 1'b0, "R8 out-of-range read");
    bus_stop();

    // R9 abort with stop mid-byte
    bus_start();
    send_byte(8'hDC, 1'b0, "R2 write address ack");
    send_byte(8'h01, 1'b0, "R9 index ack");
    send_byte(8'h01, 1'b0, "R9 count ack");
    for (int i = 0; i < 4; i++) put_bit(1'b1, 1'b0);
    bus_stop();
    chk_reg(1, 8'h00, "R9 no partial commit");

    // R9 abort with start mid-byte, then new transfer
    bus_start();
    send_byte(8'hDC, 1'b0, "R2 write address ack");
    send_byte(8'h01, 1'b0, "R9 index ack");
    send_byte(8'h01, 1'b0, "R9 count ack");
    for (int i = 0; i < 5; i++) put_bit(1'b1, 1'b0);
    chk_reg(1, 8'h00, "R9 partial not committed");
    bus_start();
    send_byte(8'hDC, 1'b0, "R9 address after restart ack");
    send_byte(8'h01, 1'b0, "R9 index ack");
    send_byte(8'h01, 1'b0, "R9 count ack");
    send_byte(8'h3C, 1'b0, "R9 data ack");
    bus_stop();
    chk_reg(1, 8'h3C, "R9 new transfer stored");

    // R11 short SCL pulses ignored
    bus_start();
    send_byte(8'hDC, 1'b0, "R11 address ack", 1'b1);
    send_byte(8'h09, 1'b0, "R11 index ack", 1'b1);
    send_byte(8'h01, 1'b0, "R11 count ack", 1'b1);
    send_byte(8'h6B, 1'b0, "R11 data ack", 1'b1);
    bus_stop();
    chk_reg(9, 8'h6B, "R11 reg9 despite glitches");

    wq(10);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard actual=%0d expected=%0d pending", act_q.size(), exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule